// File: doc/BRIEF.md
# Programmable Asynchronous Bus Cycle Generator

This block runs single read and write cycles on an 8-bit external bus where address and data share the same pins. A request port hands over an address, a direction flag and, for writes, a data byte. The block then plays out one bus cycle and signals the end with a one-clock done pulse. For a read, that pulse comes with the byte it captured.

The cycle is measured in functional ticks. A tick is a programmable number of base clocks long, and an optional doubling stretches every programmed time. One counter runs through the cycle. Chip select, address valid, output enable and write enable each go low when the counter reaches their own on-time and go high again at their off-time. Reads and writes have separate off-times and separate cycle lengths. The shared pins first carry the address, which an external latch captures on the rising edge of address valid. For a write the same pins then carry the data. For a read they are released.

Top module: `async_bus_cycler`

## Requirements
- R1: After reset, req_ready is 1, done is 0, rd_data is 0, all four strobes are high and ad_drive is 0. The same idle levels hold whenever no cycle is running.
- R2: Chip select is low during every tick k with cs_on <= k < off. The off value is cs_rd_off for reads and cs_wr_off for writes. If off <= on, chip select stays high for the whole cycle.
- R3: Address valid follows the rule of R2, using adv_on with adv_rd_off or adv_wr_off.
- R4: Output enable is low only in read cycles, during ticks oe_on <= k < oe_off. A write cycle never lowers it.
- R5: Write enable is low only in write cycles, during ticks we_on <= k < we_off. A read cycle never lowers it.
- R6: In a read, ad_drive is 1 with ad_out equal to the address for ticks k < oe_on, and 0 after that. In a write, ad_drive is 1 for ticks k < adv_wr_off or k < we_off. ad_out carries the address while k < adv_wr_off and the write data after that. ad_drive is never 1 while output enable is low.
- R7: A cycle with cycle time C (rd_cycle or wr_cycle; a value of 0 counts as 1) keeps req_ready at 0 for C ticks. In the clock right after that, done is 1 and req_ready is 1. done lasts exactly one clock.
- R8: In a read, ad_in is sampled in the first base clock of tick rd_access, and that value appears on rd_data with done. If rd_access >= C, rd_data keeps its previous value. A write leaves rd_data unchanged.
- R9: Each tick lasts clk_div+1 base clocks, so the divider stretches every strobe width and the cycle length in the same proportion.
- R10: When gran_x2 is 1, every programmed on-time, off-time, cycle time and access time is doubled before use.
- R11: req_valid is accepted only while req_ready is 1. A request held or changed during a running cycle does not change its address, data or direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request a bus cycle |
| req_write | input | 1 | 1 for a write cycle, 0 for a read |
| req_addr | input | 8 | Address placed on the shared pins |
| req_wdata | input | 8 | Data for a write |
| req_ready | output | 1 | 1 while idle; a request is taken on this clock |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 8 | Byte captured by the last read |
| clk_div | input | 3 | Tick length minus one, in base clocks |
| gran_x2 | input | 1 | Doubles all programmed times |
| cs_on | input | 5 | Chip select on-time |
| cs_rd_off | input | 5 | Chip select off-time, reads |
| cs_wr_off | input | 5 | Chip select off-time, writes |
| adv_on | input | 5 | Address valid on-time |
| adv_rd_off | input | 5 | Address valid off-time, reads |
| adv_wr_off | input | 5 | Address valid off-time, writes |
| oe_on | input | 5 | Output enable on-time |
| oe_off | input | 5 | Output enable off-time |
| we_on | input | 5 | Write enable on-time |
| we_off | input | 5 | Write enable off-time |
| rd_cycle | input | 5 | Read cycle length in ticks |
| wr_cycle | input | 5 | Write cycle length in ticks |
| rd_access | input | 5 | Read sample tick |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ad_drive | output | 1 | Enable for the pad's tri-state driver |
| ad_out | output | 8 | Value driven on the shared pins |
| ad_in | input | 8 | Value read back from the shared pins |

## Verification
The bench uses the default widths: 5-bit timing fields, a 3-bit divider and an 8-bit bus. It sweeps the divider over 0, 1 and 2, sets the doubling off and on, and runs both cycle types against four timing sets. These are the nominal long timing, a short staggered one, a degenerate one with empty windows and a zero cycle time, and one whose access tick falls beyond the cycle. Together they reach the empty-window rule, the zero-length cycle, the held read data and the 62-tick doubled cycle. Every base clock of every cycle is compared with values worked out from tick arithmetic.

// File: rtl/async_bus_cycler.sv
module async_bus_cycler #(
  parameter int TW = 5,
  parameter int DW = 3,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [AW-1:0] rd_data,
  input  logic [DW-1:0] clk_div,
  input  logic          gran_x2,
  input  logic [TW-1:0] cs_on,
  input  logic [TW-1:0] cs_rd_off,
  input  logic [TW-1:0] cs_wr_off,
  input  logic [TW-1:0] adv_on,
  input  logic [TW-1:0] adv_rd_off,
  input  logic [TW-1:0] adv_wr_off,
  input  logic [TW-1:0] oe_on,
  input  logic [TW-1:0] oe_off,
  input  logic [TW-1:0] we_on,
  input  logic [TW-1:0] we_off,
  input  logic [TW-1:0] rd_cycle,
  input  logic [TW-1:0] wr_cycle,
  input  logic [TW-1:0] rd_access,
  output logic          cs_n,
  output logic          adv_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          ad_drive,
  output logic [AW-1:0] ad_out,
  input  logic [AW-1:0] ad_in
);
  localparam int CW = TW + 1;
  localparam logic [CW:0]   ONE_X = (CW+1)'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [DW-1:0] ONE_D = DW'(1);

  logic          active, wr, done_q;
  logic [AW-1:0] addr_q, wdata_q, rdata_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dc;

  function automatic logic [CW-1:0] scale(input logic [TW-1:0] v, input logic x2);
    return x2 ? {v, 1'b0} : {1'b0, v};
  endfunction

  logic [CW-1:0] cyc_e, acc_e, cs_on_e, cs_off_e, adv_on_e, adv_off_e;
  logic [CW-1:0] oe_on_e, oe_off_e, we_on_e, we_off_e;

  assign cyc_e     = scale(wr ? wr_cycle : rd_cycle, gran_x2);
  assign acc_e     = scale(rd_access, gran_x2);
  assign cs_on_e   = scale(cs_on, gran_x2);
  assign cs_off_e  = scale(wr ? cs_wr_off : cs_rd_off, gran_x2);
  assign adv_on_e  = scale(adv_on, gran_x2);
  assign adv_off_e = scale(wr ? adv_wr_off : adv_rd_off, gran_x2);
  assign oe_on_e   = scale(oe_on, gran_x2);
  assign oe_off_e  = scale(oe_off, gran_x2);
  assign we_on_e   = scale(we_on, gran_x2);
  assign we_off_e  = scale(we_off, gran_x2);

  logic tick, last;
  assign tick = active && (dc == clk_div);
  assign last = tick && (({1'b0, cnt} + ONE_X) >= {1'b0, cyc_e});

  function automatic logic inside_win(input logic [CW-1:0] c, input logic [CW-1:0] on,
                                      input logic [CW-1:0] off);
    return (c >= on) && (c < off);
  endfunction

  assign cs_n  = !(active && inside_win(cnt, cs_on_e, cs_off_e));
  assign adv_n = !(active && inside_win(cnt, adv_on_e, adv_off_e));
  assign oe_n  = !(active && !wr && inside_win(cnt, oe_on_e, oe_off_e));
  assign we_n  = !(active && wr && inside_win(cnt, we_on_e, we_off_e));

  assign ad_drive = active && (wr ? (cnt < adv_off_e || cnt < we_off_e) : (cnt < oe_on_e));
  assign ad_out   = (!wr || cnt < adv_off_e) ? addr_q : wdata_q;

  assign req_ready = !active;
  assign done      = done_q;
  assign rd_data   = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wr      <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt     <= '0;
      dc      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (req_valid) begin
          active  <= 1'b1;
          wr      <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= '0;
          dc      <= '0;
        end
      end else begin
        if (!wr && dc == '0 && cnt == acc_e)
          rdata_q <= ad_in;
        if (tick) begin
          dc <= '0;
          if (last) begin
            active <= 1'b0;
            done_q <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + ONE_C;
          end
        end else begin
          dc <= dc + ONE_D;
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && adv_n && oe_n && we_n && !ad_drive));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_drive);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follows_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!req_ready));

  p_strobes_hold_in_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(tick)) |->
      ($stable(cs_n) && $stable(adv_n) && $stable(oe_n) && $stable(we_n)));

  p_request_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(wr)));
endmodule

// File: tb/async_bus_cycler_test.sv
module async_bus_cycler_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_write, req_ready, done, gran_x2;
  logic [7:0] req_addr, req_wdata, rd_data, ad_out, ad_in, rd_pat;
  logic [2:0] clk_div;
  logic [4:0] t_cs_on, t_cs_rd, t_cs_wr, t_adv_on, t_adv_rd, t_adv_wr;
  logic [4:0] t_oe_on, t_oe_off, t_we_on, t_we_off, t_rcyc, t_wcyc, t_acc;
  logic cs_n, adv_n, oe_n, we_n, ad_drive;

  assign ad_in = oe_n ? 8'h00 : rd_pat;

  async_bus_cycler uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .clk_div(clk_div), .gran_x2(gran_x2),
    .cs_on(t_cs_on), .cs_rd_off(t_cs_rd), .cs_wr_off(t_cs_wr),
    .adv_on(t_adv_on), .adv_rd_off(t_adv_rd), .adv_wr_off(t_adv_wr),
    .oe_on(t_oe_on), .oe_off(t_oe_off), .we_on(t_we_on), .we_off(t_we_off),
    .rd_cycle(t_rcyc), .wr_cycle(t_wcyc), .rd_access(t_acc),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
    .ad_drive(ad_drive), .ad_out(ad_out), .ad_in(ad_in));

  int checks = 0, errors = 0, exp_rd = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sc(input int v);
    return gran_x2 ? 2 * v : v;
  endfunction

  function automatic int inwin(input int k, input int on, input int off);
    return (k >= sc(on) && k < sc(off)) ? 1 : 0;
  endfunction

  task automatic set_timing(input int s);
    case (s)
      0: begin t_cs_on=0; t_cs_rd=30; t_cs_wr=30; t_adv_on=0; t_adv_rd=2; t_adv_wr=2;
               t_oe_on=3; t_oe_off=30; t_we_on=4; t_we_off=27; t_rcyc=31; t_wcyc=30; t_acc=27; end
      1: begin t_cs_on=1; t_cs_rd=6; t_cs_wr=5; t_adv_on=0; t_adv_rd=2; t_adv_wr=1;
               t_oe_on=2; t_oe_off=6; t_we_on=3; t_we_off=5; t_rcyc=7; t_wcyc=6; t_acc=4; end
      2: begin t_cs_on=3; t_cs_rd=3; t_cs_wr=2; t_adv_on=0; t_adv_rd=0; t_adv_wr=0;
               t_oe_on=5; t_oe_off=2; t_we_on=4; t_we_off=4; t_rcyc=0; t_wcyc=0; t_acc=0; end
      default: begin t_cs_on=0; t_cs_rd=4; t_cs_wr=4; t_adv_on=1; t_adv_rd=3; t_adv_wr=3;
               t_oe_on=1; t_oe_off=8; t_we_on=1; t_we_off=8; t_rcyc=5; t_wcyc=5; t_acc=9; end
    endcase
  endtask

  task automatic run(input bit w, input logic [7:0] a, input logic [7:0] d, input logic [7:0] pat);
    int dd, cyc, total, k, acc, drv, cs_off, adv_off;
    dd  = int'(clk_div) + 1;
    cyc = sc(w ? int'(t_wcyc) : int'(t_rcyc));
    if (cyc == 0) cyc = 1;
    total   = cyc * dd;
    cs_off  = w ? int'(t_cs_wr) : int'(t_cs_rd);
    adv_off = w ? int'(t_adv_wr) : int'(t_adv_rd);
    acc = sc(int'(t_acc));
    if (!w && acc < cyc)
      exp_rd = inwin(acc, int'(t_oe_on), int'(t_oe_off)) ? int'(pat) : 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; rd_pat = pat;
    @(posedge clk);
    for (int j = 0; j <= total; j++) begin
      @(negedge clk);
      if (j < total) begin
        k = j / dd;
        chk("R11 ready low while busy", int'(req_ready), 0);
        chk("R2 R9 R10 cs_n", int'(cs_n), 1 - inwin(k, int'(t_cs_on), cs_off));
        chk("R3 R9 R10 adv_n", int'(adv_n), 1 - inwin(k, int'(t_adv_on), adv_off));
        chk("R4 oe_n", int'(oe_n), w ? 1 : 1 - inwin(k, int'(t_oe_on), int'(t_oe_off)));
        chk("R5 we_n", int'(we_n), w ? 1 - inwin(k, int'(t_we_on), int'(t_we_off)) : 1);
        drv = w ? ((k < sc(int'(t_adv_wr)) || k < sc(int'(t_we_off))) ? 1 : 0)
                : ((k < sc(int'(t_oe_on))) ? 1 : 0);
        chk("R6 ad_drive", int'(ad_drive), drv);
        if (drv == 1)
          chk("R6 R11 ad_out", int'(ad_out),
              (w && k >= sc(int'(t_adv_wr))) ? int'(d) : int'(a));
        if (j == 0) begin
          req_write = ~w; req_addr = ~a; req_wdata = ~d;
        end
      end else begin
        chk("R7 R9 R10 done at cycle end", int'(done), 1);
        chk("R7 ready at cycle end", int'(req_ready), 1);
        chk("R8 rd_data", int'(rd_data), exp_rd);
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7 done single clock", int'(done), 0);
    chk("R1 idle strobes", int'({cs_n, adv_n, oe_n, we_n, ad_drive}), 5'b11110);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rd_pat = '0; clk_div = '0; gran_x2 = 1'b0;
    set_timing(0);
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset strobes", int'({cs_n, adv_n, oe_n, we_n, ad_drive}), 5'b11110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({cs_n, adv_n, oe_n, we_n, ad_drive}), 5'b11110);
    for (int s = 0; s < 4; s++)
      for (int dv = 0; dv < 3; dv++)
        for (int g = 0; g < 2; g++)
          for (int w = 0; w < 2; w++) begin
            set_timing(s);
            clk_div = 3'(dv);
            gran_x2 = g[0];
            run(w[0], 8'(8'h31 + s * 16 + dv * 4 + g * 2 + w), 8'(8'hC4 ^ (s * 8 + dv)),
                8'(8'h5A ^ (s * 16 + dv * 4 + g * 2 + w)));
          end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule